// File: doc/BRIEF.md
# Paged SPI Register Access Sequencer

This block sits on the host side of an SPI link to a peripheral whose registers are split into pages. A client hands it one register request at a time: a read, a write or a masked read-modify-write. The block turns each request into byte-level frames for a simple SPI byte serializer and reports completion with a one-cycle done pulse that carries the read data and an error flag.

The block remembers which page the target currently has selected. A page-select frame goes out only when a request names a different page. The block then updates its copy of the page, but only if that frame completed cleanly. Each register's byte count comes from a width field inside the request. A read-modify-write holds the engine busy from its read frame to its write frame, so no other request can slip in between them.

States and transitions:
- `ST_IDLE` goes to `ST_PG_ISSUE` on a request whose page misses the cache, or to `ST_AC_ISSUE` on a hit.
- `ST_PG_ISSUE` goes to `ST_PG_WAIT`.
- `ST_PG_WAIT` goes back to `ST_PG_ISSUE` for the next byte, to `ST_GAP` after the second byte, or to `ST_FIN` on an error.
- `ST_GAP` goes to `ST_AC_ISSUE`.
- `ST_AC_ISSUE` goes to `ST_AC_WAIT`.
- `ST_AC_WAIT` goes back to `ST_AC_ISSUE` for the next byte. After the last byte it goes to `ST_RMW_GAP` when the read half of a read-modify-write has finished, and otherwise to `ST_FIN`. On an error it goes to `ST_FIN`.
- `ST_RMW_GAP` goes to `ST_AC_ISSUE`.
- `ST_FIN` goes to `ST_IDLE`.

Top module: `spi_reg_seq`

## Requirements
- R1: The request word `req_reg` holds the width code in bits 17:16, the page in bits 15:8 and the in-page address in bits 7:0. Width code 2'b10 selects a two-byte register; every other code selects one byte. `req_op` selects the request kind: 2'b00 read, 2'b01 write, 2'b10 read-modify-write; 2'b11 behaves as a read.
- R2: After reset the cached page is 0, so a request to page 0 sends no page-select frame.
- R3: When the requested page differs from the cache, a two-byte frame {0x01, page} precedes the access and the cache then takes the new page. A request to the cached page sends no page-select frame.
- R4: `spi_cs` is high for the whole of every frame and low for at least one cycle between any two frames, and every frame opens with a byte start.
- R5: A read frame sends the address with bit 7 set, then one 0x00 byte for each register byte. `rd_data` is the received bytes assembled first-byte-most-significant, zero-extended for one-byte registers.
- R6: A write frame sends the address with bit 7 clear, then the low data byte for a one-byte register, or the high byte followed by the low byte for a two-byte register.
- R7: A read-modify-write sends a read frame, then a write frame carrying (old & ~mask) | (new & mask). `rd_data` reports the old value.
- R8: `req_ready` is high only while the engine is idle, including straight after reset. A request is accepted in the cycle in which `req_valid` and `req_ready` are both high. `req_ready` stays low until that request's done pulse has passed.
- R9: `done` is high for exactly one cycle per request, one cycle after the final byte completion, together with `rd_data` and `done_err`.
- R10: An error on a page-select byte ends the request at once with `done_err` set. No access frame follows, and the cache keeps its old page, so the next request to that page resends the page-select frame.
- R11: An error on an access byte ends the request with `done_err` set and no further bytes. For a read-modify-write whose read fails, no write frame is sent and the register keeps its value.
- R12: At most one byte is in flight. After a byte start, no further start is issued until that byte's completion has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_op | input | 2 | Request kind |
| req_reg | input | 18 | Width code, page and address |
| req_wdata | input | 16 | Write value or new bits for read-modify-write |
| req_mask | input | 16 | Bit mask for read-modify-write |
| spi_cs | output | 1 | Frame select, high during a frame |
| xfer_start | output | 1 | Pulse: serializer sends `xfer_tx` |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_done | input | 1 | Pulse: serializer finished the byte |
| xfer_rx | input | 8 | Byte shifted in, valid with `xfer_done` |
| xfer_err | input | 1 | Byte failed, valid with `xfer_done` |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Request ended in error, valid with `done` |
| rd_data | output | 16 | Read result, valid with `done` |

## Verification
The bench builds the block with its default parameters: page-select command byte 0x01 and read flag at address bit 7. Its serializer answers every byte two cycles after the start, which exposes the byte handshake and the one-outstanding-byte rule. The reference model keeps its own page copy and a sparse register image, so the tests reach cache hits and misses, read-modify-writes across a page change, one-byte and two-byte registers, and errors injected on a page byte, a data byte and the read half of a read-modify-write.

// File: rtl/spi_reg_seq_pkg.sv
package spi_reg_seq_pkg;
    localparam int BYTE_W   = 8;
    localparam int DATA_W   = 2 * BYTE_W;
    localparam int WCODE_W  = 2;
    localparam int REQ_W    = WCODE_W + 2 * BYTE_W;
    localparam logic [WCODE_W-1:0] WCODE_TWO = 2'b10;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_RMW   = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PG_ISSUE,
        ST_PG_WAIT,
        ST_GAP,
        ST_AC_ISSUE,
        ST_AC_WAIT,
        ST_RMW_GAP,
        ST_FIN
    } state_e;
endpackage

// File: rtl/page_cache.sv
module page_cache #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [PAGE_W-1:0] upd_page,
    input  logic [PAGE_W-1:0] cmp_page,
    output logic              miss
);
    logic [PAGE_W-1:0] page_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            page_q <= '0;
        else if (upd_en)
            page_q <= upd_page;
    end

    assign miss = (page_q != cmp_page);

    AST_CACHE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(page_q)); // R10
    AST_CACHE_TAKES_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (page_q == $past(upd_page))); // R3
endmodule

// File: rtl/frame_byte_mux.sv
module frame_byte_mux
    import spi_reg_seq_pkg::*;
#(
    parameter logic [BYTE_W-1:0] PAGE_SEL_CMD = 8'h01,
    parameter int                RD_FLAG_BIT  = 7
) (
    input  logic              pg_frame,
    input  logic [1:0]        idx,
    input  logic [BYTE_W-1:0] page,
    input  logic [BYTE_W-1:0] addr,
    input  logic              wr,
    input  logic              two,
    input  logic [DATA_W-1:0] wval,
    output logic [BYTE_W-1:0] tx
);
    localparam logic [BYTE_W-1:0] RD_FLAG = BYTE_W'(1) << RD_FLAG_BIT;

    always_comb begin
        tx = '0;
        if (pg_frame) begin
            tx = (idx == 2'd0) ? PAGE_SEL_CMD : page;
        end else begin
            unique case (idx)
                2'd0: tx = wr ? (addr & ~RD_FLAG) : (addr | RD_FLAG);
                2'd1: tx = !wr ? '0 : (two ? wval[DATA_W-1:BYTE_W] : wval[BYTE_W-1:0]);
                2'd2: tx = wr ? wval[BYTE_W-1:0] : '0;
                default: tx = '0;
            endcase
        end
    end
endmodule

// File: rtl/spi_reg_seq.sv
module spi_reg_seq
    import spi_reg_seq_pkg::*;
#(
    parameter logic [7:0] PAGE_SEL_CMD = 8'h01,
    parameter int         RD_FLAG_BIT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [REQ_W-1:0]  req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_mask,
    output logic              spi_cs,
    output logic              xfer_start,
    output logic [BYTE_W-1:0] xfer_tx,
    input  logic              xfer_done,
    input  logic [BYTE_W-1:0] xfer_rx,
    input  logic              xfer_err,
    output logic              done,
    output logic              done_err,
    output logic [DATA_W-1:0] rd_data
);
    state_e state_q, state_d;

    op_e               op_q;
    logic              two_q;
    logic [BYTE_W-1:0] page_q;
    logic [BYTE_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] rdbuf_q;
    logic [1:0]        idx_q;
    logic              wr_phase_q;
    logic              err_q;

    logic              miss;
    logic              cache_upd;
    logic [1:0]        last_idx;
    logic [DATA_W-1:0] wval;

    wire [BYTE_W-1:0] in_page = req_reg[2*BYTE_W-1:BYTE_W];

    assign last_idx  = two_q ? 2'd2 : 2'd1;
    assign wval      = (op_q == OP_RMW) ? ((rdbuf_q & ~mask_q) | (wdata_q & mask_q)) : wdata_q;
    assign cache_upd = (state_q == ST_PG_WAIT) && xfer_done && !xfer_err && (idx_q == 2'd1);

    page_cache #(.PAGE_W(BYTE_W)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (cache_upd),
        .upd_page (page_q),
        .cmp_page (in_page),
        .miss     (miss)
    );

    frame_byte_mux #(.PAGE_SEL_CMD(PAGE_SEL_CMD), .RD_FLAG_BIT(RD_FLAG_BIT)) u_mux (
        .pg_frame (state_q == ST_PG_ISSUE),
        .idx      (idx_q),
        .page     (page_q),
        .addr     (addr_q),
        .wr       (wr_phase_q),
        .two      (two_q),
        .wval     (wval),
        .tx       (xfer_tx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = miss ? ST_PG_ISSUE : ST_AC_ISSUE;
            ST_PG_ISSUE: state_d = ST_PG_WAIT;
            ST_PG_WAIT: begin
                if (xfer_done) begin
                    if (xfer_err)            state_d = ST_FIN;
                    else if (idx_q == 2'd1)  state_d = ST_GAP;
                    else                     state_d = ST_PG_ISSUE;
                end
            end
            ST_GAP:      state_d = ST_AC_ISSUE;
            ST_AC_ISSUE: state_d = ST_AC_WAIT;
            ST_AC_WAIT: begin
                if (xfer_done) begin
                    if (xfer_err)                state_d = ST_FIN;
                    else if (idx_q != last_idx)  state_d = ST_AC_ISSUE;
                    else if (!wr_phase_q && op_q == OP_RMW) state_d = ST_RMW_GAP;
                    else                         state_d = ST_FIN;
                end
            end
            ST_RMW_GAP:  state_d = ST_AC_ISSUE;
            ST_FIN:      state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Request and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_READ;
            two_q      <= 1'b0;
            page_q     <= '0;
            addr_q     <= '0;
            wdata_q    <= '0;
            mask_q     <= '0;
            rdbuf_q    <= '0;
            idx_q      <= '0;
            wr_phase_q <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q       <= op_e'(req_op);
                        two_q      <= (req_reg[REQ_W-1:2*BYTE_W] == WCODE_TWO);
                        page_q     <= in_page;
                        addr_q     <= req_reg[BYTE_W-1:0];
                        wdata_q    <= req_wdata;
                        mask_q     <= req_mask;
                        rdbuf_q    <= '0;
                        idx_q      <= '0;
                        wr_phase_q <= (op_e'(req_op) == OP_WRITE);
                        err_q      <= 1'b0;
                    end
                end
                ST_PG_WAIT: begin
                    if (xfer_done) begin
                        if (xfer_err) err_q <= 1'b1;
                        else          idx_q <= (idx_q == 2'd1) ? 2'd0 : idx_q + 2'd1;
                    end
                end
                ST_AC_WAIT: begin
                    if (xfer_done) begin
                        if (xfer_err) begin
                            err_q <= 1'b1;
                        end else begin
                            if (!wr_phase_q && idx_q != 2'd0)
                                rdbuf_q <= {rdbuf_q[BYTE_W-1:0], xfer_rx};
                            idx_q <= (idx_q == last_idx) ? 2'd0 : idx_q + 2'd1;
                        end
                    end
                end
                ST_RMW_GAP: wr_phase_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        spi_cs     = (state_q == ST_PG_ISSUE) || (state_q == ST_PG_WAIT) ||
                     (state_q == ST_AC_ISSUE) || (state_q == ST_AC_WAIT);
        xfer_start = (state_q == ST_PG_ISSUE) || (state_q == ST_AC_ISSUE);
        done       = (state_q == ST_FIN);
        done_err   = (state_q == ST_FIN) && err_q;
        rd_data    = (state_q == ST_FIN) ? rdbuf_q : '0;
    end

    AST_START_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> spi_cs); // R4
    AST_FRAME_OPENS_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs) |-> xfer_start); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start); // R12
endmodule

// File: tb/spi_reg_seq_test.sv
module spi_reg_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [17:0] req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] req_mask = '0;
    logic        spi_cs, xfer_start;
    logic [7:0]  xfer_tx;
    logic        xfer_done = 1'b0;
    logic [7:0]  xfer_rx = '0;
    logic        xfer_err = 1'b0;
    logic        done, done_err;
    logic [15:0] rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_reg_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_reg(req_reg), .req_wdata(req_wdata), .req_mask(req_mask),
        .spi_cs(spi_cs), .xfer_start(xfer_start), .xfer_tx(xfer_tx),
        .xfer_done(xfer_done), .xfer_rx(xfer_rx), .xfer_err(xfer_err),
        .done(done), .done_err(done_err), .rd_data(rd_data)
    );

    typedef struct {
        bit         first;
        logic [7:0] tx;
        logic [7:0] rx;
        bit         err;
        bit         last;
        bit         rdbyte;
        string      tag;
    } exp_t;

    exp_t        expq[$];
    logic [15:0] mem[int];
    logic [7:0]  model_page = 8'h00;
    bit          busy = 1'b0;
    logic [15:0] exp_rdata = '0;
    bit          exp_err = 1'b0;
    string       req_tag = "R9";
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done_due = 1'b0;
    int          pend = 0;
    exp_t        cur;
    bit          cs_prev = 1'b0;
    bit          running = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_rd(input int key);
        if (mem.exists(key)) return mem[key];
        return 16'(key ^ 32'h5A3C);
    endfunction

    // Serializer model and per-clock comparison
    always @(negedge clk) begin
        if (running) begin
            check(done == done_due, "R9", "done timing", 32'(done), 32'(done_due));
            if (done) begin
                check(rd_data == exp_rdata, req_tag, "rd_data", 32'(rd_data), 32'(exp_rdata));
                check(done_err == exp_err, req_tag, "done_err", 32'(done_err), 32'(exp_err));
                busy = 1'b0;
            end
            done_due = 1'b0;
            xfer_done = 1'b0;
            xfer_err  = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    xfer_done = 1'b1;
                    xfer_rx   = cur.rx;
                    xfer_err  = cur.err;
                    if (cur.last) done_due = 1'b1;
                end
            end
            if (xfer_start) begin
                if (pend > 0) begin
                    check(1'b0, "R12", "start while byte in flight", 32'd1, 32'd0);
                end else if (expq.size() == 0) begin
                    check(1'b0, "R3", "unexpected byte", 32'(xfer_tx), 32'hFFFF);
                end else begin
                    cur = expq.pop_front();
                    check(xfer_tx == cur.tx, cur.tag, "tx byte", 32'(xfer_tx), 32'(cur.tx));
                    check((!cs_prev) == cur.first, "R4", "frame boundary",
                          32'(!cs_prev), 32'(cur.first));
                    pend = LAT;
                end
            end
            cs_prev = spi_cs;
        end
    end

    task automatic do_req(input logic [1:0] op, input logic [1:0] wcode,
                          input logic [7:0] page, input logic [7:0] addr,
                          input logic [15:0] wd, input logic [15:0] mask,
                          input int err_idx, input string tag);
        exp_t lst[$];
        exp_t e;
        int nb = (wcode == 2'b10) ? 2 : 1;
        bit pg = (page != model_page);
        bit is_wr = (op == 2'b01);
        bit is_rmw = (op == 2'b10);
        int key = {16'd0, page, addr};
        logic [15:0] old = mem_rd(key);
        logic [15:0] wv;
        logic [15:0] rd = '0;
        bit has_err;
        if (nb == 1) old = old & 16'h00FF;
        wv = is_rmw ? ((old & ~mask) | (wd & mask)) : wd;
        if (pg) begin
            e = '{1'b1, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, "R3"}; lst.push_back(e);
            e = '{1'b0, page, 8'h00, 1'b0, 1'b0, 1'b0, "R3"};  lst.push_back(e);
        end
        if (!is_wr) begin
            e = '{1'b1, addr | 8'h80, 8'h00, 1'b0, 1'b0, 1'b0, "R5"}; lst.push_back(e);
            for (int i = 0; i < nb; i++) begin
                e = '{1'b0, 8'h00, (nb == 2 && i == 0) ? old[15:8] : old[7:0],
                      1'b0, 1'b0, 1'b1, "R5"};
                lst.push_back(e);
            end
        end
        if (is_wr || is_rmw) begin
            e = '{1'b1, addr & 8'h7F, 8'h00, 1'b0, 1'b0, 1'b0, is_rmw ? "R7" : "R6"};
            lst.push_back(e);
            for (int i = 0; i < nb; i++) begin
                e = '{1'b0, (nb == 2 && i == 0) ? wv[15:8] : wv[7:0], 8'h00,
                      1'b0, 1'b0, 1'b0, is_rmw ? "R7" : "R6"};
                lst.push_back(e);
            end
        end
        has_err = (err_idx >= 0) && (err_idx < lst.size());
        if (has_err) begin
            lst[err_idx].err = 1'b1;
            while (lst.size() > err_idx + 1) void'(lst.pop_back());
        end
        lst[lst.size()-1].last = 1'b1;
        foreach (lst[i]) if (lst[i].rdbyte && !lst[i].err) rd = {rd[7:0], lst[i].rx};
        if (pg && !(has_err && err_idx < 2)) model_page = page;
        if (!has_err && (is_wr || is_rmw)) mem[key] = (nb == 1) ? {8'h00, wv[7:0]} : wv;

        while (busy) @(posedge clk);
        @(posedge clk); #1;
        check(req_ready == 1'b1, "R8", "ready when idle", 32'(req_ready), 32'd1);
        foreach (lst[i]) expq.push_back(lst[i]);
        exp_rdata = rd;
        exp_err   = has_err;
        req_tag   = tag;
        busy      = 1'b1;
        req_valid = 1'b1;
        req_op    = op;
        req_reg   = {wcode, page, addr};
        req_wdata = wd;
        req_mask  = mask;
        @(posedge clk); #1;
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R8", "ready low while busy", 32'(req_ready), 32'd0);
        while (busy) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "R9", "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R8", "reset ready", 32'(req_ready), 32'd1);
        check(spi_cs == 1'b0, "R4", "reset cs", 32'(spi_cs), 32'd0);
        check(xfer_start == 1'b0, "R12", "reset start", 32'(xfer_start), 32'd0);
        check(done == 1'b0, "R9", "reset done", 32'(done), 32'd0);
        running = 1'b1;

        do_req(2'b00, 2'b10, 8'h00, 8'h10, 16'h0000, 16'h0000, -1, "R2");
        do_req(2'b01, 2'b01, 8'h00, 8'h04, 16'h773C, 16'h0000, -1, "R6");
        do_req(2'b00, 2'b01, 8'h00, 8'h04, 16'h0000, 16'h0000, -1, "R5");
        do_req(2'b01, 2'b10, 8'h02, 8'h15, 16'hBEEF, 16'h0000, -1, "R3");
        do_req(2'b00, 2'b10, 8'h02, 8'h15, 16'h0000, 16'h0000, -1, "R3");
        do_req(2'b10, 2'b10, 8'h02, 8'h15, 16'h1234, 16'h00F0, -1, "R7");
        do_req(2'b00, 2'b10, 8'h02, 8'h15, 16'h0000, 16'h0000, -1, "R7");
        do_req(2'b10, 2'b01, 8'h0E, 8'h30, 16'h0020, 16'h0030, -1, "R7");
        do_req(2'b00, 2'b01, 8'h0E, 8'h30, 16'h0000, 16'h0000, -1, "R7");
        do_req(2'b00, 2'b10, 8'h03, 8'h10, 16'h0000, 16'h0000, 1, "R10");
        do_req(2'b00, 2'b10, 8'h03, 8'h10, 16'h0000, 16'h0000, 0, "R10");
        do_req(2'b00, 2'b10, 8'h03, 8'h10, 16'h0000, 16'h0000, -1, "R10");
        do_req(2'b00, 2'b10, 8'h03, 8'h11, 16'h0000, 16'h0000, 2, "R11");
        do_req(2'b10, 2'b10, 8'h03, 8'h12, 16'hFFFF, 16'hFFFF, 1, "R11");
        do_req(2'b00, 2'b10, 8'h03, 8'h12, 16'h0000, 16'h0000, -1, "R11");
        do_req(2'b11, 2'b11, 8'h03, 8'h13, 16'hAAAA, 16'hFFFF, -1, "R1");
        do_req(2'b01, 2'b00, 8'h00, 8'h05, 16'hC3A5, 16'h0000, -1, "R1");
        do_req(2'b00, 2'b01, 8'h00, 8'h05, 16'h0000, 16'h0000, -1, "R1");

        repeat (5) @(posedge clk);
        #1;
        check(expq.size() == 0, "R3", "bytes left unsent", 32'(expq.size()), 32'd0);
        check(spi_cs == 1'b0, "R4", "cs idle at end", 32'(spi_cs), 32'd0);
        finish_run();
    end
endmodule